// File: doc/BRIEF.md
# Multi-Mode Load Address Generator

This block forms the memory address for a load and, for the modes that move a pointer, the pointer's new value. A request carries a mode code, an element-size flag (byte or halfword), the current pointer or base, an index, an immediate, a shift amount, an absolute constant, a modifier word and a circular-buffer start. One clock after a request is accepted the block presents the effective address, the next pointer value and a write-enable that tells the register file whether to store that pointer.

Eight modes are covered: base plus scaled immediate, shifted index plus constant, absolute with pointer load, post-increment by immediate or by modifier, bit-reversed post-increment for FFT-style buffers, and two circular post-increment forms. One takes its step from the immediate. The other takes its step from a signed 7-bit field packed into the modifier beside the 17-bit buffer length, scaled by the element size. All arithmetic is 32-bit and wraps modulo 2^32.

Top module: `load_addr_gen`

## Requirements
- R1: While rstN is low and after its release until the first request, rspValid and rspPtrWe are 0 and rspAddr and rspPtr are 0.
- R2: rspValid is high in exactly the cycle after a cycle in which reqValid was high at the clock edge. Each request gives one response, in order.
- R3: Mode 0 (base plus immediate): rspAddr = ptrIn + (immIn shifted left by 1 if elemHalf is 1, by 0 if it is 0). The pointer is not written.
- R4: Mode 1 (scaled index): rspAddr = (idxIn << shiftIn) + absIn. The pointer is not written.
- R5: Mode 2 (absolute): rspAddr = absIn and rspPtr = absIn with rspPtrWe = 1.
- R6: Mode 3 (post-increment by immediate): rspAddr = ptrIn and rspPtr = ptrIn + immIn.
- R7: Mode 4 (post-increment by modifier): rspAddr = ptrIn and rspPtr = ptrIn + modIn.
- R8: Mode 5 (bit-reversed): rspAddr keeps ptrIn bits 31:16, and its bits 15:0 are ptrIn bits 15:0 in reversed order (bit k takes ptrIn bit 15-k). rspPtr = ptrIn + modIn.
- R9: Mode 6 (circular by immediate): the length L is modIn bits 16:0. rspAddr = ptrIn and rspPtr = startIn + ((ptrIn - startIn + immIn) mod L), with the remainder taken in the range 0..L-1, for a signed immIn.
- R10: Mode 7 (circular by register): the step is the signed 7-bit field modIn bits 23:17, multiplied by 2 when elemHalf is 1. Otherwise it behaves as R9 with that step.
- R11: rspPtrWe is 1 only with rspValid and only for modes 2 to 7. When it is 0, rspPtr equals the ptrIn of that request.
- R12: Every sum and shift wraps modulo 2^32, so a pointer or address that passes 0xFFFFFFFF continues from 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request present this cycle |
| mode | input | 3 | Addressing mode code 0..7 |
| elemHalf | input | 1 | 1 for halfword elements, 0 for bytes |
| ptrIn | input | 32 | Base or pointer register value |
| idxIn | input | 32 | Index register value |
| immIn | input | 32 | Immediate offset or increment |
| shiftIn | input | 5 | Index shift amount |
| absIn | input | 32 | Absolute constant |
| modIn | input | 32 | Modifier word (increment, or length and packed step) |
| startIn | input | 32 | Circular buffer start |
| rspValid | output | 1 | Response present |
| rspAddr | output | 32 | Effective load address |
| rspPtr | output | 32 | Next pointer value |
| rspPtrWe | output | 1 | Pointer write-back enable |

## Verification
The circular-range assertion assumes that, in modes 6 and 7, the incoming pointer already lies inside the buffer (0 <= ptrIn - startIn < L) and that the step's magnitude is below L. A single add or subtract of L then brings the pointer back into range. The random circular stimulus draws a start, a length of at least 200 and a pointer offset below that length, and it bounds the immediate step to less than the length. A 7-bit register step times two never exceeds 128, so it stays inside that bound too. The bit-reversed, hold and timing assertions make no assumption about the inputs beyond reqValid being low during reset.

// File: rtl/lag_pkg.sv
package lag_pkg;

  typedef enum logic [2:0] {
    MODE_BASE_IMM = 3'd0,
    MODE_IDX_ABS  = 3'd1,
    MODE_ABS_WB   = 3'd2,
    MODE_POST_IMM = 3'd3,
    MODE_POST_MOD = 3'd4,
    MODE_BITREV   = 3'd5,
    MODE_CIRC_IMM = 3'd6,
    MODE_CIRC_REG = 3'd7
  } lagMode_e;

  typedef enum logic [2:0] {
    ADDR_PTR_IMM = 3'd0,
    ADDR_IDX     = 3'd1,
    ADDR_ABS     = 3'd2,
    ADDR_PTR     = 3'd3,
    ADDR_BREV    = 3'd4
  } addrSel_e;

  typedef enum logic [1:0] {
    NPTR_ABS  = 2'd0,
    NPTR_IMM  = 2'd1,
    NPTR_MOD  = 2'd2,
    NPTR_CIRC = 2'd3
  } ptrSel_e;

  typedef struct packed {
    logic     capture;
    addrSel_e addrSel;
    ptrSel_e  ptrSel;
    logic     ptrWe;
    logic     circReg;
  } lagStrobe_t;

endpackage

// File: rtl/lag_ctrl.sv
module lag_ctrl
  import lag_pkg::*;
(
  input  logic       reqValid,
  input  logic [2:0] mode,
  output lagStrobe_t strobes
);

  lagMode_e modeE;
  assign modeE = lagMode_e'(mode);

  always_comb begin
    strobes         = '0;
    strobes.capture = reqValid;
    strobes.addrSel = ADDR_PTR;
    strobes.ptrSel  = NPTR_IMM;
    strobes.ptrWe   = 1'b0;
    strobes.circReg = 1'b0;
    unique case (modeE)
      MODE_BASE_IMM: strobes.addrSel = ADDR_PTR_IMM;
      MODE_IDX_ABS:  strobes.addrSel = ADDR_IDX;
      MODE_ABS_WB: begin
        strobes.addrSel = ADDR_ABS;
        strobes.ptrSel  = NPTR_ABS;
        strobes.ptrWe   = reqValid;
      end
      MODE_POST_IMM: begin
        strobes.ptrSel = NPTR_IMM;
        strobes.ptrWe  = reqValid;
      end
      MODE_POST_MOD: begin
        strobes.ptrSel = NPTR_MOD;
        strobes.ptrWe  = reqValid;
      end
      MODE_BITREV: begin
        strobes.addrSel = ADDR_BREV;
        strobes.ptrSel  = NPTR_MOD;
        strobes.ptrWe   = reqValid;
      end
      MODE_CIRC_IMM: begin
        strobes.ptrSel = NPTR_CIRC;
        strobes.ptrWe  = reqValid;
      end
      MODE_CIRC_REG: begin
        strobes.ptrSel  = NPTR_CIRC;
        strobes.circReg = 1'b1;
        strobes.ptrWe   = reqValid;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/lag_datapath.sv
module lag_datapath
  import lag_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int SHAMT_W  = 5,
  parameter int BREV_W   = 16,
  parameter int LEN_W    = 17,
  parameter int CINC_W   = 7,
  parameter int CINC_LSB = 17
) (
  input  logic               clk,
  input  logic               rstN,
  input  lagStrobe_t         strobes,
  input  logic               elemHalf,
  input  logic [ADDR_W-1:0]  ptrIn,
  input  logic [ADDR_W-1:0]  idxIn,
  input  logic [ADDR_W-1:0]  immIn,
  input  logic [SHAMT_W-1:0] shiftIn,
  input  logic [ADDR_W-1:0]  absIn,
  input  logic [ADDR_W-1:0]  modIn,
  input  logic [ADDR_W-1:0]  startIn,
  output logic               rspValid,
  output logic [ADDR_W-1:0]  rspAddr,
  output logic [ADDR_W-1:0]  rspPtr,
  output logic               rspPtrWe
);

  localparam int CINC_MSB = CINC_LSB + CINC_W - 1;

  // bit-reversed low field
  logic [BREV_W-1:0] brevLow;
  for (genvar k = 0; k < BREV_W; k++) begin : g_brev
    assign brevLow[k] = ptrIn[BREV_W-1-k];
  end

  logic [ADDR_W-1:0] scaledImm;
  logic [ADDR_W-1:0] circLen;
  logic [ADDR_W-1:0] regStep;
  logic [ADDR_W-1:0] circStep;
  logic [ADDR_W-1:0] circOff;
  logic [ADDR_W-1:0] circSum;
  logic [ADDR_W-1:0] circAdj;
  logic [ADDR_W-1:0] circPtr;
  logic [ADDR_W-1:0] addrNext;
  logic [ADDR_W-1:0] ptrNext;

  assign scaledImm = immIn << elemHalf;
  assign circLen   = {{(ADDR_W-LEN_W){1'b0}}, modIn[LEN_W-1:0]};
  assign regStep   = {{(ADDR_W-CINC_W){modIn[CINC_MSB]}}, modIn[CINC_MSB:CINC_LSB]} << elemHalf;
  assign circStep  = strobes.circReg ? regStep : immIn;
  assign circOff   = ptrIn - startIn;
  assign circSum   = circOff + circStep;

  // one correction step, valid while |step| < length
  always_comb begin
    if ($signed(circSum) < 0)
      circAdj = circSum + circLen;
    else if ($signed(circSum) >= $signed(circLen))
      circAdj = circSum - circLen;
    else
      circAdj = circSum;
  end
  assign circPtr = startIn + circAdj;

  always_comb begin
    unique case (strobes.addrSel)
      ADDR_PTR_IMM: addrNext = ptrIn + scaledImm;
      ADDR_IDX:     addrNext = (idxIn << shiftIn) + absIn;
      ADDR_ABS:     addrNext = absIn;
      ADDR_BREV:    addrNext = {ptrIn[ADDR_W-1:BREV_W], brevLow};
      default:      addrNext = ptrIn;
    endcase
  end

  always_comb begin
    if (!strobes.ptrWe)
      ptrNext = ptrIn;
    else begin
      unique case (strobes.ptrSel)
        NPTR_ABS:  ptrNext = absIn;
        NPTR_IMM:  ptrNext = ptrIn + immIn;
        NPTR_MOD:  ptrNext = ptrIn + modIn;
        default:   ptrNext = circPtr;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspAddr  <= '0;
      rspPtr   <= '0;
      rspPtrWe <= 1'b0;
    end else begin
      rspValid <= strobes.capture;
      rspPtrWe <= strobes.capture & strobes.ptrWe;
      if (strobes.capture) begin
        rspAddr <= addrNext;
        rspPtr  <= ptrNext;
      end
    end
  end

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.capture |=> rspValid);
  // R2
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.capture |=> !rspValid);
  // R11
  we_needs_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspPtrWe |-> rspValid);
  // R11
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.capture && !strobes.ptrWe) |=> (rspPtr == $past(ptrIn)));
  // R8
  brev_upper_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.capture && strobes.addrSel == ADDR_BREV)
      |=> (rspAddr[ADDR_W-1:BREV_W] == $past(ptrIn[ADDR_W-1:BREV_W])));
  // R9
  circ_in_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.capture && strobes.ptrWe && strobes.ptrSel == NPTR_CIRC)
      |=> ((rspPtr - $past(startIn)) < $past(circLen)));
  // R6
  post_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.capture && strobes.addrSel == ADDR_PTR) |=> (rspAddr == $past(ptrIn)));

endmodule

// File: rtl/load_addr_gen.sv
module load_addr_gen
  import lag_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int SHAMT_W  = 5,
  parameter int BREV_W   = 16,
  parameter int LEN_W    = 17,
  parameter int CINC_W   = 7,
  parameter int CINC_LSB = 17
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic [2:0]         mode,
  input  logic               elemHalf,
  input  logic [ADDR_W-1:0]  ptrIn,
  input  logic [ADDR_W-1:0]  idxIn,
  input  logic [ADDR_W-1:0]  immIn,
  input  logic [SHAMT_W-1:0] shiftIn,
  input  logic [ADDR_W-1:0]  absIn,
  input  logic [ADDR_W-1:0]  modIn,
  input  logic [ADDR_W-1:0]  startIn,
  output logic               rspValid,
  output logic [ADDR_W-1:0]  rspAddr,
  output logic [ADDR_W-1:0]  rspPtr,
  output logic               rspPtrWe
);

  lagStrobe_t strobes;

  lag_ctrl u_ctrl (
    .reqValid (reqValid),
    .mode     (mode),
    .strobes  (strobes)
  );

  lag_datapath #(
    .ADDR_W   (ADDR_W),
    .SHAMT_W  (SHAMT_W),
    .BREV_W   (BREV_W),
    .LEN_W    (LEN_W),
    .CINC_W   (CINC_W),
    .CINC_LSB (CINC_LSB)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .elemHalf (elemHalf),
    .ptrIn    (ptrIn),
    .idxIn    (idxIn),
    .immIn    (immIn),
    .shiftIn  (shiftIn),
    .absIn    (absIn),
    .modIn    (modIn),
    .startIn  (startIn),
    .rspValid (rspValid),
    .rspAddr  (rspAddr),
    .rspPtr   (rspPtr),
    .rspPtrWe (rspPtrWe)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rstN |=> (!rspValid && !rspPtrWe));

endmodule

// File: tb/load_addr_gen_tb_top.sv
`timescale 1ns/1ps
module load_addr_gen_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [2:0]  mode = '0;
  logic        elemHalf = 1'b0;
  logic [31:0] ptrIn = '0, idxIn = '0, immIn = '0, absIn = '0, modIn = '0, startIn = '0;
  logic [4:0]  shiftIn = '0;
  logic        rspValid, rspPtrWe;
  logic [31:0] rspAddr, rspPtr;

  always #4 clk = ~clk;

  load_addr_gen dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .mode(mode), .elemHalf(elemHalf),
    .ptrIn(ptrIn), .idxIn(idxIn), .immIn(immIn), .shiftIn(shiftIn), .absIn(absIn),
    .modIn(modIn), .startIn(startIn), .rspValid(rspValid), .rspAddr(rspAddr),
    .rspPtr(rspPtr), .rspPtrWe(rspPtrWe)
  );

  typedef struct {
    logic [31:0] addr;
    logic [31:0] ptr;
    logic        we;
    string       tag;
  } expItem_t;

  expItem_t    sbQueue[$];
  int          totalCnt = 0;
  int          failCnt = 0;
  logic [31:0] lastPtr;
  bit          doneFlag = 0;

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    totalCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic void model(input int m, input bit hs, input logic [31:0] p, input logic [31:0] ix,
                                input logic [31:0] im, input logic [4:0] sh, input logic [31:0] ab,
                                input logic [31:0] md, input logic [31:0] st,
                                output logic [31:0] ea, output logic [31:0] np, output logic we);
    longint len, step, off;
    ea = p; np = p; we = 1'b0;
    case (m)
      0: ea = p + (hs ? im * 2 : im);
      1: ea = (ix << sh) + ab;
      2: begin ea = ab; np = ab; we = 1'b1; end
      3: begin np = p + im; we = 1'b1; end
      4: begin np = p + md; we = 1'b1; end
      5: begin
        for (int k = 0; k < 16; k++) ea[k] = p[15-k];
        np = p + md; we = 1'b1;
      end
      default: begin
        len  = longint'(md[16:0]);
        step = (m == 6) ? longint'($signed(im)) : longint'($signed(md[23:17])) * (hs ? 2 : 1);
        off  = longint'(p - st) + step;
        off  = ((off % len) + len) % len;
        np   = st + 32'(off);
        we   = 1'b1;
      end
    endcase
  endfunction

  task automatic sendReq(input int m, input bit hs, input logic [31:0] p, input logic [31:0] ix,
                         input logic [31:0] im, input logic [4:0] sh, input logic [31:0] ab,
                         input logic [31:0] md, input logic [31:0] st, input string tag);
    expItem_t e;
    model(m, hs, p, ix, im, sh, ab, md, st, e.addr, e.ptr, e.we);
    e.tag = tag;
    @(negedge clk);
    reqValid = 1'b1; mode = 3'(m); elemHalf = hs; ptrIn = p; idxIn = ix; immIn = im;
    shiftIn = sh; absIn = ab; modIn = md; startIn = st;
    sbQueue.push_back(e);
    lastPtr = e.ptr;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      reqValid = 1'b0;
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rstN && rspValid) begin
      if (sbQueue.size() == 0) begin
        check("R2", "unexpected rspValid", 32'(rspValid), 32'd0);
      end else begin
        expItem_t e;
        e = sbQueue.pop_front();
        check(e.tag, "addr", rspAddr, e.addr);
        check(e.tag, "ptr", rspPtr, e.ptr);
        check("R11", "ptrWe", 32'(rspPtrWe), 32'(e.we));
      end
    end
  end

  // watchdog
  initial begin
    #1000000;
    if (!doneFlag) begin
      totalCnt++; failCnt++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", totalCnt - failCnt, totalCnt);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "rspValid", 32'(rspValid), 0);
    check("R1", "rspPtrWe", 32'(rspPtrWe), 0);
    check("R1", "rspAddr", rspAddr, 0);
    check("R1", "rspPtr", rspPtr, 0);
    rstN = 1'b1;
    idle(2);
    check("R1", "rspValid after release", 32'(rspValid), 0);
    check("R1", "rspPtr after release", rspPtr, 0);

    // R3 base plus immediate, byte and halfword
    sendReq(0, 0, 32'h1000, 0, 32'd3, 0, 0, 0, 0, "R3");
    sendReq(0, 1, 32'h1000, 0, 32'd3, 0, 0, 0, 0, "R3");
    // R4 scaled index
    sendReq(1, 0, 32'h55, 32'd3, 0, 5'd1, 32'h8000, 0, 0, "R4");
    sendReq(1, 1, 32'h55, 32'd7, 0, 5'd4, 32'h100, 0, 0, "R4");
    // R5 absolute
    sendReq(2, 0, 32'h1, 0, 0, 0, 32'hABCD_0010, 0, 0, "R5");
    // R6 post-increment chain
    sendReq(3, 1, 32'h2000, 0, 32'd2, 0, 0, 0, 0, "R6");
    for (int k = 0; k < 3; k++) sendReq(3, 1, lastPtr, 0, 32'd2, 0, 0, 0, 0, "R6");
    // R7 post-increment by modifier
    sendReq(4, 0, 32'h3000, 0, 0, 0, 0, 32'h40, 0, "R7");
    sendReq(4, 0, lastPtr, 0, 0, 0, 0, 32'hFFFF_FFF0, 0, "R7");
    // R8 bit-reversed, addresses base+0,+4,+2,+6
    sendReq(5, 0, 32'h0001_0000, 0, 0, 0, 0, 32'h2000, 0, "R8");
    for (int k = 0; k < 3; k++) sendReq(5, 0, lastPtr, 0, 0, 0, 0, 32'h2000, 0, "R8");
    // R9 circular by immediate, length 2 step 1, then step -1 length 5
    sendReq(6, 0, 32'h4000, 0, 32'd1, 0, 0, 32'd2, 32'h4000, "R9");
    for (int k = 0; k < 3; k++) sendReq(6, 0, lastPtr, 0, 32'd1, 0, 0, 32'd2, 32'h4000, "R9");
    sendReq(6, 0, 32'h4000, 0, 32'hFFFF_FFFF, 0, 0, 32'd5, 32'h4000, "R9");
    // R10 circular by register, length 4 step 1 halfword, then negative step
    sendReq(7, 1, 32'h5000, 0, 0, 0, 0, (32'd1 << 17) | 32'd4, 32'h5000, "R10");
    for (int k = 0; k < 3; k++) sendReq(7, 1, lastPtr, 0, 0, 0, 0, (32'd1 << 17) | 32'd4, 32'h5000, "R10");
    sendReq(7, 0, 32'h5001, 0, 0, 0, 0, (32'h7E << 17) | 32'd9, 32'h5000, "R10");
    // R12 wraparound
    sendReq(3, 0, 32'hFFFF_FFFE, 0, 32'd4, 0, 0, 0, 0, "R12");
    sendReq(0, 1, 32'hFFFF_FFFF, 0, 32'd1, 0, 0, 0, 0, "R12");
    sendReq(1, 0, 0, 32'h8000_0001, 0, 5'd1, 32'hFFFF_FFFF, 0, 0, "R12");
    idle(3);
    // R2 no response without request
    check("R2", "idle rspValid", 32'(rspValid), 0);

    // mixed random traffic with gaps
    for (int n = 0; n < 400; n++) begin
      int m;
      bit hs;
      logic [31:0] st, md, im, p;
      m  = int'($urandom % 8);
      hs = bit'($urandom % 2);
      if (m >= 6) begin
        st = $urandom;
        md = 32'(200 + $urandom % 1000);
        p  = st + ($urandom % md);
        im = 32'($signed(int'($urandom % (2 * md - 1)) - int'(md) + 1));
        md = md | (($urandom % 128) << 17);
      end else begin
        st = $urandom; md = $urandom; im = $urandom; p = $urandom;
      end
      sendReq(m, hs, p, $urandom, im, 5'($urandom), $urandom, md, st, "R11");
      if ($urandom % 4 == 0) idle(1);
    end
    idle(4);
    check("R2", "queue drained", 32'(sbQueue.size()), 0);
    doneFlag = 1;
    $display("%0d/%0d checks passed", totalCnt - failCnt, totalCnt);
    $finish;
  end

endmodule